// File: doc/BRIEF.md
# Quarter-rate I/Q breakdown detector

This block watches two RF pickups of a high-gradient accelerating structure, one carrying forward power and one carrying reflected power. Each arrives as a stream of signed ADC samples of an intermediate-frequency signal that is sampled at exactly four times its own frequency, one sample per clock. Because of this sampling ratio, consecutive samples carry the in-phase and quadrature components in turn, with the sign flipping every half period. The block turns each stream into baseband I/Q pairs at half the sample rate by routing samples and flipping signs, with no mixer or oscillator. It then forms the squared magnitude of each pair as a power figure.

A breakdown is declared when the reflected power exceeds 0.23 % of the forward power, which corresponds to a VSWR of 1.1. The test is a cross-multiplication of the two power figures, so no divider is needed. The test only counts while a window input marks the RF pulse, so noise between pulses cannot trip it. Each new detection gives a one-cycle event. It also sets a level output that holds off RF drive and the amplifier and modulator triggers for a programmable number of clock ticks. In the field this count corresponds to ten seconds.

A pulse-start strobe realigns the sample phase at the start of every RF macro pulse and re-arms the per-pulse event.

Top module: `bd_iq_detector`

## Requirements
- R1: The sample presented together with `pulse_start` is phase 0. Later samples take phases 1, 2, 3, 0, ... in turn until the next `pulse_start`, wherever the count was.
- R2: `iq_valid` is high for exactly one cycle after each phase-1 or phase-3 sample, so one pair is produced per two input samples and never two pairs in a row.
- R3: A pair completed at phase 1 has I = phase-0 sample and Q = phase-1 sample. A pair completed at phase 3 has I = minus the phase-2 sample and Q = minus the phase-3 sample. The I/Q outputs are one bit wider than the samples, so a full-scale negative sample negates to +2^(SMP_W-1) without wrapping.
- R4: `pwr_valid` is high in the cycle after each `iq_valid` cycle. The power outputs then hold I*I + Q*Q of that pair for each channel.
- R5: A pair trips when refl_pwr × 10000 is strictly greater than fwd_pwr × 23, computed exactly without overflow. Equality does not trip.
- R6: A pair trips only if `gate` was high on both of its samples. Pairs with `gate` low cause no event and no inhibit.
- R7: `bd_event` is high for one cycle, in the cycle after the `pwr_valid` cycle of the first tripping pair of a pulse. Later trips in the same pulse raise no event; `pulse_start` re-arms it.
- R8: A trip loads the hold-off count from `hold_ticks`. `rf_inhibit` is high from the cycle after the trip for exactly that many cycles. A count of zero gives no inhibit.
- R9: A trip while `rf_inhibit` is already high reloads the count, so the inhibit lasts `hold_ticks` cycles after the last trip. This applies within one pulse and across pulses.
- R10: During and right after reset, `iq_valid`, `pwr_valid`, `bd_event` and `rf_inhibit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one ADC sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_start | input | 1 | Strobe on the first sample of an RF macro pulse |
| gate | input | 1 | High while the RF pulse window is open |
| fwd_smp | input | SMP_W | Signed forward-power pickup sample |
| refl_smp | input | SMP_W | Signed reflected-power pickup sample |
| hold_ticks | input | HOLD_W | Hold-off length in clock ticks |
| iq_valid | output | 1 | A new I/Q pair is present on both channels |
| fwd_i | output | SMP_W+1 | Forward baseband in-phase value |
| fwd_q | output | SMP_W+1 | Forward baseband quadrature value |
| refl_i | output | SMP_W+1 | Reflected baseband in-phase value |
| refl_q | output | SMP_W+1 | Reflected baseband quadrature value |
| pwr_valid | output | 1 | New power figures are present |
| fwd_pwr | output | 2*(SMP_W+1) | Forward squared magnitude |
| refl_pwr | output | 2*(SMP_W+1) | Reflected squared magnitude |
| bd_event | output | 1 | One-cycle pulse on a new breakdown in this pulse |
| rf_inhibit | output | 1 | Holds off RF drive and triggers while high |

## Verification
Constant-envelope pulses have a reflected amplitude placed just under and just over the 0.23 % line: a power of 9194 against 9216 with a forward power of 4,000,000. These show whether the comparison is strict and exact. The same tripping pulse is run with the window closed, with a zero hold count and with back-to-back trips. This tells apart gating, the hold-off load and the reload rule, and the inhibit length is counted in cycles. A pulse restart part-way through a phase cycle and a run of full-scale negative samples check the phase rotation and the sign handling. Random pulses vary amplitude, ratio, window, gap and hold count, and every output is compared each cycle with a model built from the requirements.

// File: rtl/bdd_pkg.sv
package bdd_pkg;

   // Position of a sample inside one IF period sampled four times.
   typedef enum logic [1:0] {
      PH_I  = 2'd0,
      PH_Q  = 2'd1,
      PH_NI = 2'd2,
      PH_NQ = 2'd3
   } quad_ph_e;

   // Width needed so that power times the larger ratio term cannot overflow.
   function automatic int cmp_width(input int pwr_w, input int num, input int den);
      int big;
      big = (num > den) ? num : den;
      return pwr_w + $clog2(big + 1);
   endfunction

endpackage

// File: rtl/bdd_phase_seq.sv
module bdd_phase_seq
   import bdd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   output quad_ph_e phase
);

   quad_ph_e ph_q;

   // A restart forces the present sample to phase 0.
   assign phase = restart ? PH_I : ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_I;
      end else begin
         ph_q <= quad_ph_e'(phase + 2'd1);
      end
   end

endmodule

// File: rtl/bdd_quad_demod.sv
module bdd_quad_demod
   import bdd_pkg::*;
#(
   parameter int SMP_W = 14
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  quad_ph_e                phase,
   input  logic signed [SMP_W-1:0] smp,
   input  logic                    win,
   output logic                    out_valid,
   output logic signed [SMP_W:0]   out_i,
   output logic signed [SMP_W:0]   out_q,
   output logic                    out_win
);

   logic signed [SMP_W:0] s_pos;
   logic signed [SMP_W:0] s_neg;
   logic signed [SMP_W:0] held;
   logic                  held_win;

   // One extra bit so that negating the most negative code stays exact.
   assign s_pos = {smp[SMP_W-1], smp};
   assign s_neg = -s_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= '0;
         held_win  <= 1'b0;
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         out_win   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         unique case (phase)
            PH_I: begin
               held     <= s_pos;
               held_win <= win;
            end
            PH_NI: begin
               held     <= s_neg;
               held_win <= win;
            end
            PH_Q: begin
               out_i     <= held;
               out_q     <= s_pos;
               out_win   <= held_win & win;
               out_valid <= 1'b1;
            end
            PH_NQ: begin
               out_i     <= held;
               out_q     <= s_neg;
               out_win   <= held_win & win;
               out_valid <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/bdd_power.sv
module bdd_power #(
   parameter int IN_W  = 15,
   parameter int PWR_W = 30
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_i,
   input  logic signed [IN_W-1:0] in_q,
   input  logic                   in_win,
   output logic                   pwr_valid,
   output logic [PWR_W-1:0]       pwr,
   output logic                   pwr_win
);

   logic signed [PWR_W-1:0] i_wide;
   logic signed [PWR_W-1:0] q_wide;
   logic signed [PWR_W-1:0] mag_sq;

   assign i_wide = PWR_W'(in_i);
   assign q_wide = PWR_W'(in_q);
   assign mag_sq = i_wide * i_wide + q_wide * q_wide;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_valid <= 1'b0;
         pwr       <= '0;
         pwr_win   <= 1'b0;
      end else begin
         pwr_valid <= in_valid;
         pwr_win   <= in_win;
         if (in_valid) begin
            pwr <= $unsigned(mag_sq);
         end
      end
   end

endmodule

// File: rtl/bdd_trip_ctl.sv
module bdd_trip_ctl
   import bdd_pkg::*;
#(
   parameter int PWR_W     = 30,
   parameter int HOLD_W    = 24,
   parameter int RATIO_NUM = 23,
   parameter int RATIO_DEN = 10000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pulse_start,
   input  logic              pwr_valid,
   input  logic              pwr_win,
   input  logic [PWR_W-1:0]  fwd_pwr,
   input  logic [PWR_W-1:0]  refl_pwr,
   input  logic [HOLD_W-1:0] hold_ticks,
   output logic              bd_event,
   output logic              rf_inhibit
);

   localparam int CMP_W = cmp_width(PWR_W, RATIO_NUM, RATIO_DEN);

   logic [CMP_W-1:0]  refl_scaled;
   logic [CMP_W-1:0]  fwd_scaled;
   logic              trip;
   logic              seen_in_pulse;
   logic [HOLD_W-1:0] hold_cnt;

   // Ratio test by cross-multiplication: refl/fwd > NUM/DEN.
   assign refl_scaled = CMP_W'(refl_pwr) * CMP_W'(RATIO_DEN);
   assign fwd_scaled  = CMP_W'(fwd_pwr) * CMP_W'(RATIO_NUM);
   assign trip        = pwr_valid & pwr_win & (refl_scaled > fwd_scaled);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bd_event      <= 1'b0;
         seen_in_pulse <= 1'b0;
         hold_cnt      <= '0;
      end else begin
         bd_event      <= trip & ~seen_in_pulse;
         seen_in_pulse <= pulse_start ? 1'b0 : (seen_in_pulse | trip);
         if (trip) begin
            hold_cnt <= hold_ticks;
         end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - HOLD_W'(1);
         end
      end
   end

   assign rf_inhibit = (hold_cnt != '0);

endmodule

// File: rtl/bd_iq_detector.sv
module bd_iq_detector
   import bdd_pkg::*;
#(
   parameter int SMP_W     = 14,
   parameter int HOLD_W    = 24,
   parameter int RATIO_NUM = 23,
   parameter int RATIO_DEN = 10000
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pulse_start,
   input  logic                         gate,
   input  logic signed [SMP_W-1:0]      fwd_smp,
   input  logic signed [SMP_W-1:0]      refl_smp,
   input  logic [HOLD_W-1:0]            hold_ticks,
   output logic                         iq_valid,
   output logic signed [SMP_W:0]        fwd_i,
   output logic signed [SMP_W:0]        fwd_q,
   output logic signed [SMP_W:0]        refl_i,
   output logic signed [SMP_W:0]        refl_q,
   output logic                         pwr_valid,
   output logic [2*(SMP_W+1)-1:0]       fwd_pwr,
   output logic [2*(SMP_W+1)-1:0]       refl_pwr,
   output logic                         bd_event,
   output logic                         rf_inhibit
);

   localparam int DEM_W = SMP_W + 1;
   localparam int PWR_W = 2 * DEM_W;
   localparam int N_CH  = 2;   // channel 0 forward, channel 1 reflected

   if (SMP_W < 4 || SMP_W > 24) begin : g_bad_smp_w
      $error("bd_iq_detector: SMP_W out of supported range");
   end
   if (HOLD_W < 1) begin : g_bad_hold_w
      $error("bd_iq_detector: HOLD_W must be at least 1");
   end
   if (RATIO_NUM < 1 || RATIO_DEN <= RATIO_NUM) begin : g_bad_ratio
      $error("bd_iq_detector: ratio must be a proper positive fraction");
   end

   quad_ph_e phase;

   logic signed [SMP_W-1:0] ch_smp   [N_CH];
   logic                    ch_iqv   [N_CH];
   logic signed [DEM_W-1:0] ch_i     [N_CH];
   logic signed [DEM_W-1:0] ch_q     [N_CH];
   logic                    ch_iqwin [N_CH];
   logic                    ch_pv    [N_CH];
   logic [PWR_W-1:0]        ch_pwr   [N_CH];
   logic                    ch_pwin  [N_CH];

   assign ch_smp[0] = fwd_smp;
   assign ch_smp[1] = refl_smp;

   bdd_phase_seq u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (pulse_start),
      .phase   (phase)
   );

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      bdd_quad_demod #(
         .SMP_W (SMP_W)
      ) u_demod (
         .clk       (clk),
         .rst_n     (rst_n),
         .phase     (phase),
         .smp       (ch_smp[ch]),
         .win       (gate),
         .out_valid (ch_iqv[ch]),
         .out_i     (ch_i[ch]),
         .out_q     (ch_q[ch]),
         .out_win   (ch_iqwin[ch])
      );

      bdd_power #(
         .IN_W  (DEM_W),
         .PWR_W (PWR_W)
      ) u_power (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (ch_iqv[ch]),
         .in_i      (ch_i[ch]),
         .in_q      (ch_q[ch]),
         .in_win    (ch_iqwin[ch]),
         .pwr_valid (ch_pv[ch]),
         .pwr       (ch_pwr[ch]),
         .pwr_win   (ch_pwin[ch])
      );
   end

   assign iq_valid  = ch_iqv[0] & ch_iqv[1];
   assign fwd_i     = ch_i[0];
   assign fwd_q     = ch_q[0];
   assign refl_i    = ch_i[1];
   assign refl_q    = ch_q[1];
   assign pwr_valid = ch_pv[0] & ch_pv[1];
   assign fwd_pwr   = ch_pwr[0];
   assign refl_pwr  = ch_pwr[1];

   bdd_trip_ctl #(
      .PWR_W     (PWR_W),
      .HOLD_W    (HOLD_W),
      .RATIO_NUM (RATIO_NUM),
      .RATIO_DEN (RATIO_DEN)
   ) u_trip (
      .clk         (clk),
      .rst_n       (rst_n),
      .pulse_start (pulse_start),
      .pwr_valid   (pwr_valid),
      .pwr_win     (ch_pwin[0] & ch_pwin[1]),
      .fwd_pwr     (fwd_pwr),
      .refl_pwr    (refl_pwr),
      .hold_ticks  (hold_ticks),
      .bd_event    (bd_event),
      .rf_inhibit  (rf_inhibit)
   );

endmodule

// File: rtl/bd_iq_detector_chk.sv
module bd_iq_detector_chk #(
   parameter int HOLD_W = 24
)(
   input logic              clk,
   input logic              rst_n,
   input logic [HOLD_W-1:0] hold_ticks,
   input logic              iq_valid,
   input logic              pwr_valid,
   input logic              bd_event,
   input logic              rf_inhibit
);

   p_no_back_to_back_pairs_r2: assert property (
      @(posedge clk) disable iff (!rst_n) iq_valid |=> !iq_valid);

   p_pwr_follows_pair_r4: assert property (
      @(posedge clk) disable iff (!rst_n) iq_valid |=> pwr_valid);

   p_pwr_only_after_pair_r4: assert property (
      @(posedge clk) disable iff (!rst_n) !iq_valid |=> !pwr_valid);

   p_event_after_power_r7: assert property (
      @(posedge clk) disable iff (!rst_n) bd_event |-> $past(pwr_valid));

   p_event_single_cycle_r7: assert property (
      @(posedge clk) disable iff (!rst_n) bd_event |=> !bd_event);

   p_event_sets_inhibit_r8: assert property (
      @(posedge clk) disable iff (!rst_n)
      (bd_event && $past(hold_ticks) != '0) |-> rf_inhibit);

endmodule

bind bd_iq_detector bd_iq_detector_chk #(
   .HOLD_W (HOLD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hold_ticks (hold_ticks),
   .iq_valid   (iq_valid),
   .pwr_valid  (pwr_valid),
   .bd_event   (bd_event),
   .rf_inhibit (rf_inhibit)
);

// File: tb/bd_iq_detector_tb.sv
`timescale 1ns/1ps
module bd_iq_detector_tb;

   localparam int SMP_W  = 14;
   localparam int HOLD_W = 24;
   localparam longint NUM = 23;
   localparam longint DEN = 10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_start = 1'b0;
   logic gate = 1'b0;
   logic signed [SMP_W-1:0] fwd_smp = '0;
   logic signed [SMP_W-1:0] refl_smp = '0;
   logic [HOLD_W-1:0] hold_ticks = '0;
   logic iq_valid, pwr_valid, bd_event, rf_inhibit;
   logic signed [SMP_W:0] fwd_i, fwd_q, refl_i, refl_q;
   logic [2*(SMP_W+1)-1:0] fwd_pwr, refl_pwr;

   always #4 clk = ~clk;   // 125 MHz

   bd_iq_detector #(.SMP_W(SMP_W), .HOLD_W(HOLD_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .pulse_start(pulse_start), .gate(gate),
      .fwd_smp(fwd_smp), .refl_smp(refl_smp), .hold_ticks(hold_ticks),
      .iq_valid(iq_valid), .fwd_i(fwd_i), .fwd_q(fwd_q),
      .refl_i(refl_i), .refl_q(refl_q), .pwr_valid(pwr_valid),
      .fwd_pwr(fwd_pwr), .refl_pwr(refl_pwr),
      .bd_event(bd_event), .rf_inhibit(rf_inhibit)
   );

   int n_chk = 0;
   int n_err = 0;
   int ev_seen = 0;
   int inh_cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model from the requirements ----------------
   int     m_ph, m_hf, m_hr, sf, sr, ph;
   bit     m_hg, m_iqg, m_pg, m_det, tripd;
   longint m_cnt;
   bit     e_iqv, e_pv, e_ev, e_inh;
   longint e_fi, e_fq, e_ri, e_rq, e_fp, e_rp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_hf = 0; m_hr = 0; m_hg = 0; m_iqg = 0; m_pg = 0;
         m_det = 0; m_cnt = 0;
         e_iqv = 0; e_pv = 0; e_ev = 0; e_inh = 0;
         e_fi = 0; e_fq = 0; e_ri = 0; e_rq = 0; e_fp = 0; e_rp = 0;
      end else begin
         // decision on the powers present before this edge (R5, R6)
         tripd = e_pv && m_pg && (e_rp * DEN > e_fp * NUM);
         // power stage (R4)
         if (e_iqv) begin
            e_fp = e_fi * e_fi + e_fq * e_fq;
            e_rp = e_ri * e_ri + e_rq * e_rq;
         end
         e_pv = e_iqv;
         m_pg = m_iqg;
         // demodulation stage (R1, R2, R3)
         ph = pulse_start ? 0 : m_ph;
         sf = fwd_smp;
         sr = refl_smp;
         e_iqv = 0;
         case (ph)
            0: begin m_hf = sf;  m_hr = sr;  m_hg = gate; end
            2: begin m_hf = -sf; m_hr = -sr; m_hg = gate; end
            1: begin e_fi = m_hf; e_fq = sf;  e_ri = m_hr; e_rq = sr;
                     m_iqg = m_hg && gate; e_iqv = 1; end
            default: begin e_fi = m_hf; e_fq = -sf; e_ri = m_hr; e_rq = -sr;
                     m_iqg = m_hg && gate; e_iqv = 1; end
         endcase
         m_ph = (ph + 1) % 4;
         // event and hold-off (R7, R8, R9)
         e_ev  = tripd && !m_det;
         m_det = pulse_start ? 0 : (m_det || tripd);
         if (tripd) m_cnt = longint'(hold_ticks);
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         e_inh = (m_cnt != 0);
      end
   end

   // ---------------- per-cycle comparison, away from the active edge ----------------
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(bd_event == e_ev, "R7 bd_event", longint'(bd_event), longint'(e_ev));
         chk(rf_inhibit == e_inh, "R8/R9 rf_inhibit", longint'(rf_inhibit), longint'(e_inh));
         chk(iq_valid == e_iqv, "R2 iq_valid", longint'(iq_valid), longint'(e_iqv));
         chk(pwr_valid == e_pv, "R4 pwr_valid", longint'(pwr_valid), longint'(e_pv));
         if (e_iqv) begin
            chk(longint'(fwd_i) == e_fi, "R1/R3 fwd_i", longint'(fwd_i), e_fi);
            chk(longint'(fwd_q) == e_fq, "R1/R3 fwd_q", longint'(fwd_q), e_fq);
            chk(longint'(refl_i) == e_ri, "R1/R3 refl_i", longint'(refl_i), e_ri);
            chk(longint'(refl_q) == e_rq, "R1/R3 refl_q", longint'(refl_q), e_rq);
         end
         if (e_pv) begin
            chk(longint'(fwd_pwr) == e_fp, "R4 fwd_pwr", longint'(fwd_pwr), e_fp);
            chk(longint'(refl_pwr) == e_rp, "R4 refl_pwr", longint'(refl_pwr), e_rp);
         end
         if (bd_event) ev_seen++;
         if (rf_inhibit) inh_cyc++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drv(input bit ps, input bit g, input int f, input int r);
      @(negedge clk);
      pulse_start = ps;
      gate        = g;
      fwd_smp     = SMP_W'(f);
      refl_smp    = SMP_W'(r);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++)
         drv(0, 0, int'($urandom_range(0, 40)) - 20, int'($urandom_range(0, 40)) - 20);
   endtask

   task automatic pulse(input int pairs, input int fi, input int fq,
                        input int ri, input int rq, input bit g, input int gap);
      for (int k = 0; k < 2 * pairs; k++) begin
         int f, r;
         case (k % 4)
            0: begin f = fi;  r = ri;  end
            1: begin f = fq;  r = rq;  end
            2: begin f = -fi; r = -ri; end
            default: begin f = -fq; r = -rq; end
         endcase
         drv(k == 0, g, f, r);
      end
      idle(gap);
   endtask

   task automatic snap(output int e, output int h);
      @(posedge clk);
      e = ev_seen;
      h = inh_cyc;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   // ---------------- test sequence ----------------
   initial begin
      int e0, h0, e1, h1;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10: outputs low while reset is held
      chk(!iq_valid && !pwr_valid && !bd_event && !rf_inhibit, "R10 reset state",
          longint'({iq_valid, pwr_valid, bd_event, rf_inhibit}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!iq_valid && !pwr_valid && !bd_event && !rf_inhibit, "R10 after reset",
          longint'({iq_valid, pwr_valid, bd_event, rf_inhibit}), 0);
      idle(6);

      // R1: restart mid-cycle, the phase count realigns to the new strobe
      hold_ticks = 24'd5;
      drv(1, 1, 700, 3); drv(0, 1, -500, 2); drv(0, 1, 900, 1);
      pulse(6, 1234, -4321, 11, 7, 1, 20);

      // R3: full-scale negative samples negate without wrapping
      for (int k = 0; k < 8; k++) drv(k == 0, 1, -8192, 0);
      idle(10);

      // R5: just under the ratio line, no trip
      hold_ticks = 24'd10;
      snap(e0, h0);
      pulse(8, 2000, 0, 95, 13, 1, 40);
      snap(e1, h1);
      chk(e1 - e0 == 0, "R5 below threshold events", e1 - e0, 0);
      chk(h1 - h0 == 0, "R5 below threshold inhibit", h1 - h0, 0);

      // R5, R7, R9: just over the line, every pair trips, single event, reload
      snap(e0, h0);
      pulse(8, 2000, 0, 96, 0, 1, 40);
      snap(e1, h1);
      chk(e1 - e0 == 1, "R7 one event per pulse", e1 - e0, 1);
      chk(h1 - h0 == 24, "R9 reload within pulse inhibit cycles", h1 - h0, 24);

      // R6: window closed, large reflection ignored
      snap(e0, h0);
      pulse(8, 2000, 0, 1500, 0, 0, 30);
      snap(e1, h1);
      chk(e1 - e0 == 0, "R6 gate low events", e1 - e0, 0);
      chk(h1 - h0 == 0, "R6 gate low inhibit", h1 - h0, 0);

      // R8: zero hold count, event but no inhibit
      hold_ticks = 24'd0;
      snap(e0, h0);
      pulse(1, 2000, 0, 1500, 0, 1, 20);
      snap(e1, h1);
      chk(e1 - e0 == 1, "R8 zero hold event", e1 - e0, 1);
      chk(h1 - h0 == 0, "R8 zero hold inhibit", h1 - h0, 0);

      // R8: exact hold length for one trip
      hold_ticks = 24'd13;
      snap(e0, h0);
      pulse(1, 2000, 0, 1500, 0, 1, 30);
      snap(e1, h1);
      chk(h1 - h0 == 13, "R8 hold length", h1 - h0, 13);

      // R9, R7: second pulse trips during hold-off, re-armed event and reload
      hold_ticks = 24'd30;
      snap(e0, h0);
      pulse(1, 3000, 100, 2000, 0, 1, 6);
      pulse(1, 3000, 100, 2000, 0, 1, 50);
      snap(e1, h1);
      chk(e1 - e0 == 2, "R7 re-armed per pulse", e1 - e0, 2);
      chk(h1 - h0 == 38, "R9 reload across pulses", h1 - h0, 38);

      // random pulses against the model
      for (int n = 0; n < 80; n++) begin
         int fi, fq, s, sel;
         fi  = int'($urandom_range(0, 6000)) - 3000;
         fq  = int'($urandom_range(0, 6000)) - 3000;
         sel = int'($urandom_range(0, 2));
         s   = (sel == 0) ? 20 : ((sel == 1) ? 48 : 100);
         hold_ticks = HOLD_W'($urandom_range(0, 40));
         pulse(int'($urandom_range(2, 16)), fi, fq, fi * s / 1000, fq * s / 1000,
               $urandom_range(0, 4) != 0, int'($urandom_range(4, 50)));
      end
      idle(60);
      finish_run();
   end

endmodule